// File: doc/BRIEF.md
# Integrating Overload and Short-Circuit Fault Detector

This block sits beside the pulse sequencer of a peak-current-mode switching controller and decides when a persistent overload or a hard short must shut the converter down. Each time a drive pulse ends, the sequencer gives a one-cycle strobe and a two-bit code that says why the pulse ended. From that stream the block keeps two pieces of state: an integrating overload timer and a run counter of back-to-back short-circuit terminations.

The overload timer works as an up/down integrator in clock ticks. A current-limit termination sets it counting up on every clock. Any other termination sets it counting down. It rests at zero and stops at full scale, where it raises the overload fault. A brief overload therefore only moves the timer part of the way, and the timer bleeds back down once normal regulation resumes. A sustained overload reaches full scale. The short-circuit counter rises by one on each short-circuit termination. Any other kind of termination resets it to zero. When the counter reaches the run length, it raises the short-circuit fault.

Both faults stay set until the mode sequencer pulses the clear input. The clear also zeroes the timer and the counter.

The overload integrator has four states:
- OI_IDLE: the timer is at zero.
- OI_RISE: counting up.
- OI_FALL: counting down.
- OI_TRIP: at full scale, with the fault held.

Its transitions:
- A current-limit termination moves OI_IDLE, OI_RISE or OI_FALL to OI_RISE.
- Any other termination moves OI_RISE or OI_FALL to OI_FALL.
- Counting down to zero moves OI_FALL to OI_IDLE.
- Reaching full scale moves OI_RISE to OI_TRIP.
- The clear returns every state to OI_IDLE.

The short-circuit counter has three states:
- SR_CLEAR: the run is zero.
- SR_COUNT: part way through a run.
- SR_TRIP: the fault is held.

Its transitions:
- A short-circuit termination moves SR_CLEAR to SR_COUNT, or to SR_TRIP when the run length is 1.
- A short-circuit termination that completes the run moves SR_COUNT to SR_TRIP.
- Any other termination moves SR_COUNT back to SR_CLEAR.
- The clear returns every state to SR_CLEAR.

Top module: `ovld_scp_detector`

## Requirements
- R1: After reset, `ovld_fault` and `scp_fault` are 0, and the overload timer and short-circuit run are both zero.
- R2: A termination with code 2'b01 (current limit) makes the timer count up by one at that clock edge and at every following edge until a different termination code arrives.
- R3: A termination with code 2'b00 (PWM comparator), 2'b10 (short circuit) or 2'b11 (maximum duty) makes the timer count down by one per edge from that edge on. The timer stops at zero and is never cleared at once by these codes.
- R4: `ovld_fault` rises at the edge where the timer reaches FULL_TICKS. From then on the timer is frozen and terminations are ignored.
- R5: Each termination with code 2'b10 adds one to the run. `scp_fault` rises at the edge of the RUN_LEN-th consecutive such termination.
- R6: A termination with any code other than 2'b10 resets the run to zero. Clock cycles without a strobe do not break a run.
- R7: Both faults stay set until `fault_clr` is high at an edge. That edge zeroes both faults, the timer and the run, and wins over a termination strobed in the same cycle.
- R8: While `term_stb` is low, `term_cause` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| term_stb | input | 1 | One-cycle strobe marking the end of a drive pulse |
| term_cause | input | 2 | Why the pulse ended: 00 PWM, 01 current limit, 10 short circuit, 11 maximum duty |
| fault_clr | input | 1 | Clear from the mode sequencer |
| ovld_fault | output | 1 | Sticky overload fault request |
| scp_fault | output | 1 | Sticky short-circuit fault request |

## Verification
The hardest case to reach is a timer that has partly filled, drained part of the way, and then climbs again. The fault time there depends on the whole history of up and down ticks, not on the last event alone. The stimulus builds this on purpose: current-limit bursts separated by PWM and maximum-duty terminations, one drain that runs into the zero floor, and a final climb whose trip edge follows from the net level. Short-circuit runs are broken by each other kind of termination, and clears are made to coincide with strobes.

// File: rtl/ovld_scp_pkg.sv
`timescale 1ns/1ps
package ovld_scp_pkg;
    typedef enum logic [1:0] {
        END_PWM  = 2'b00,
        END_ILIM = 2'b01,
        END_SCP  = 2'b10,
        END_DMAX = 2'b11
    } end_cause_e;

    typedef enum logic [1:0] {
        OI_IDLE = 2'b00,
        OI_RISE = 2'b01,
        OI_FALL = 2'b10,
        OI_TRIP = 2'b11
    } oi_state_e;

    typedef enum logic [1:0] {
        SR_CLEAR = 2'b00,
        SR_COUNT = 2'b01,
        SR_TRIP  = 2'b10
    } sr_state_e;
endpackage

// File: rtl/ovld_integrator.sv
`timescale 1ns/1ps
module ovld_integrator
    import ovld_scp_pkg::*;
#(
    parameter int FULL_TICKS = 6_000_000,
    localparam int TW = $clog2(FULL_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          term_stb,
    input  logic [1:0]    term_cause,
    input  logic          fault_clr,
    output logic [TW-1:0] tmr_lvl,
    output logic          ovld_fault
);
    localparam logic [TW-1:0] FULL_V = TW'(FULL_TICKS);
    localparam logic [TW-1:0] NEAR_V = TW'(FULL_TICKS - 1);

    oi_state_e     st_q, st_n;
    logic [TW-1:0] tmr_q, tmr_n;
    logic          go_up;

    // Direction for this tick: a new termination picks it, otherwise keep it.
    assign go_up = term_stb ? (term_cause == END_ILIM) : (st_q == OI_RISE);

    always_comb begin
        st_n  = st_q;
        tmr_n = tmr_q;
        if (fault_clr) begin
            st_n  = OI_IDLE;
            tmr_n = '0;
        end else begin
            unique case (st_q)
                OI_IDLE, OI_RISE, OI_FALL: begin
                    if (go_up) begin
                        if (tmr_q >= NEAR_V) begin
                            tmr_n = FULL_V;
                            st_n  = OI_TRIP;
                        end else begin
                            tmr_n = tmr_q + 1'b1;
                            st_n  = OI_RISE;
                        end
                    end else if (tmr_q <= TW'(1)) begin
                        tmr_n = '0;
                        st_n  = OI_IDLE;
                    end else begin
                        tmr_n = tmr_q - 1'b1;
                        st_n  = OI_FALL;
                    end
                end
                OI_TRIP: begin
                    st_n  = OI_TRIP;
                    tmr_n = tmr_q;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= OI_IDLE;
            tmr_q <= '0;
        end else begin
            st_q  <= st_n;
            tmr_q <= tmr_n;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovld_fault <= 1'b0;
        else        ovld_fault <= (st_n == OI_TRIP);
    end

    assign tmr_lvl = tmr_q;
endmodule

// File: rtl/scp_run_counter.sv
`timescale 1ns/1ps
module scp_run_counter
    import ovld_scp_pkg::*;
#(
    parameter int RUN_LEN = 4,
    localparam int RW = $clog2(RUN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          term_stb,
    input  logic [1:0]    term_cause,
    input  logic          fault_clr,
    output logic [RW-1:0] run_lvl,
    output logic          scp_fault
);
    localparam logic [RW-1:0] RUN_V  = RW'(RUN_LEN);
    localparam logic [RW-1:0] LAST_V = RW'(RUN_LEN - 1);

    sr_state_e     st_q, st_n;
    logic [RW-1:0] run_q, run_n;

    always_comb begin
        st_n  = st_q;
        run_n = run_q;
        if (fault_clr) begin
            st_n  = SR_CLEAR;
            run_n = '0;
        end else begin
            unique case (st_q)
                SR_CLEAR, SR_COUNT: begin
                    if (term_stb) begin
                        if (term_cause == END_SCP) begin
                            if (run_q == LAST_V) begin
                                run_n = RUN_V;
                                st_n  = SR_TRIP;
                            end else begin
                                run_n = run_q + 1'b1;
                                st_n  = SR_COUNT;
                            end
                        end else begin
                            run_n = '0;
                            st_n  = SR_CLEAR;
                        end
                    end
                end
                SR_TRIP: begin
                    st_n  = SR_TRIP;
                    run_n = run_q;
                end
                default: begin
                    st_n  = SR_CLEAR;
                    run_n = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SR_CLEAR;
            run_q <= '0;
        end else begin
            st_q  <= st_n;
            run_q <= run_n;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scp_fault <= 1'b0;
        else        scp_fault <= (st_n == SR_TRIP);
    end

    assign run_lvl = run_q;
endmodule

// File: rtl/ovld_scp_detector.sv
`timescale 1ns/1ps
module ovld_scp_detector #(
    parameter int FULL_TICKS = 6_000_000,
    parameter int RUN_LEN    = 4,
    localparam int TW = $clog2(FULL_TICKS + 1),
    localparam int RW = $clog2(RUN_LEN + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       term_stb,
    input  logic [1:0] term_cause,
    input  logic       fault_clr,
    output logic       ovld_fault,
    output logic       scp_fault
);
    logic [TW-1:0] tmr_lvl;
    logic [RW-1:0] run_lvl;

    ovld_integrator #(.FULL_TICKS(FULL_TICKS)) u_olp (
        .clk        (clk),
        .rst_n      (rst_n),
        .term_stb   (term_stb),
        .term_cause (term_cause),
        .fault_clr  (fault_clr),
        .tmr_lvl    (tmr_lvl),
        .ovld_fault (ovld_fault)
    );

    scp_run_counter #(.RUN_LEN(RUN_LEN)) u_scp (
        .clk        (clk),
        .rst_n      (rst_n),
        .term_stb   (term_stb),
        .term_cause (term_cause),
        .fault_clr  (fault_clr),
        .run_lvl    (run_lvl),
        .scp_fault  (scp_fault)
    );
endmodule

// File: rtl/ovld_scp_detector_chk.sv
`timescale 1ns/1ps
module ovld_scp_detector_chk #(
    parameter int FULL_TICKS = 6_000_000,
    parameter int RUN_LEN    = 4,
    localparam int TW = $clog2(FULL_TICKS + 1),
    localparam int RW = $clog2(RUN_LEN + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          term_stb,
    input logic [1:0]    term_cause,
    input logic          fault_clr,
    input logic          ovld_fault,
    input logic          scp_fault,
    input logic [TW-1:0] tmr,
    input logic [RW-1:0] run
);
    localparam logic [TW-1:0] FULL_V = TW'(FULL_TICKS);
    localparam logic [RW-1:0] RUN_V  = RW'(RUN_LEN);

    AST_TMR_SLEW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fault_clr) |-> (({1'b0, tmr} == {1'b0, $past(tmr)}) ||
                               ({1'b0, tmr} == {1'b0, $past(tmr)} + 1'b1) ||
                               ({1'b0, tmr} + 1'b1 == {1'b0, $past(tmr)}))); // R2
    AST_OLP_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovld_fault) |-> (tmr == FULL_V)); // R4
    AST_TMR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        tmr <= FULL_V); // R4
    AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RUN_V); // R5
    AST_SCP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scp_fault) |-> ($past(term_stb) && ($past(term_cause) == 2'b10))); // R5
    AST_RUN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (term_stb && (term_cause != 2'b10) && !scp_fault && !fault_clr) |=> (run == '0)); // R6
    AST_OLP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovld_fault && !fault_clr) |=> ovld_fault); // R7
    AST_SCP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (scp_fault && !fault_clr) |=> scp_fault); // R7
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr |=> (!ovld_fault && !scp_fault && (tmr == '0) && (run == '0))); // R7
endmodule

bind ovld_scp_detector ovld_scp_detector_chk #(
    .FULL_TICKS (FULL_TICKS),
    .RUN_LEN    (RUN_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .term_stb   (term_stb),
    .term_cause (term_cause),
    .fault_clr  (fault_clr),
    .ovld_fault (ovld_fault),
    .scp_fault  (scp_fault),
    .tmr        (tmr_lvl),
    .run        (run_lvl)
);

// File: tb/ovld_scp_detector_tb.sv
`timescale 1ns/1ps
module ovld_scp_detector_tb;
    localparam int FULL = 40;
    localparam int RUN  = 4;
    localparam logic [1:0] C_PWM = 2'b00, C_ILIM = 2'b01, C_SCP = 2'b10, C_DMAX = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       term_stb = 1'b0;
    logic [1:0] term_cause = 2'b00;
    logic       fault_clr = 1'b0;
    logic       ovld_fault, scp_fault;

    int n_vec = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // Requirement-level model state
    int m_tmr = 0;
    bit m_up = 1'b0;
    bit m_otrip = 1'b0;
    int m_run = 0;
    bit m_strip = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    ovld_scp_detector #(.FULL_TICKS(FULL), .RUN_LEN(RUN)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .term_stb   (term_stb),
        .term_cause (term_cause),
        .fault_clr  (fault_clr),
        .ovld_fault (ovld_fault),
        .scp_fault  (scp_fault)
    );

    // Driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input bit stb, input logic [1:0] cause, input bit clr, input string tag);
        bit up;
        @(negedge clk);
        term_stb   = stb;
        term_cause = cause;
        fault_clr  = clr;
        if (clr) begin
            m_tmr = 0; m_up = 1'b0; m_otrip = 1'b0; m_run = 0; m_strip = 1'b0;
        end else begin
            if (!m_otrip) begin
                up = stb ? (cause == C_ILIM) : m_up;
                if (up) begin
                    m_tmr++;
                    m_up = 1'b1;
                    if (m_tmr >= FULL) begin m_tmr = FULL; m_otrip = 1'b1; end
                end else begin
                    if (m_tmr > 0) m_tmr--;
                    m_up = 1'b0;
                end
            end
            if (!m_strip && stb) begin
                if (cause == C_SCP) begin
                    m_run++;
                    if (m_run >= RUN) m_strip = 1'b1;
                end else begin
                    m_run = 0;
                end
            end
        end
        exp_q.push_back({m_otrip, m_strip});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, C_PWM, 1'b0, tag);
    endtask

    // Monitor: pops and compares one item after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_vec++;
                if ({ovld_fault, scp_fault} !== e) begin
                    n_err++;
                    $display("FAIL %s: {ovld,scp} actual %b expected %b at %0t", t,
                             {ovld_fault, scp_fault}, e, $time);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if ({ovld_fault, scp_fault} !== 2'b00) begin
            n_err++;
            $display("FAIL R1: reset outputs actual %b expected 00", {ovld_fault, scp_fault});
        end
        rst_n = 1'b1;
        // R1: timer starts at zero, so the first trip comes exactly FULL ticks later
        idle(3, "R1");
        // R2 / R4: one current-limit end climbs to full scale
        step(1'b1, C_ILIM, 1'b0, "R2");
        idle(FULL - 2, "R2");
        step(1'b0, C_PWM, 1'b0, "R4");
        // R4: trip frozen, other terminations ignored
        for (int i = 0; i < 5; i++) step(1'b1, C_PWM, 1'b0, "R4");
        idle(4, "R4");
        step(1'b0, C_PWM, 1'b1, "R7");
        idle(FULL + 5, "R7");
        // R3: partial fill, partial drain, refill
        step(1'b1, C_ILIM, 1'b0, "R3");
        idle(19, "R3");
        step(1'b1, C_PWM, 1'b0, "R3");
        idle(6, "R3");
        step(1'b1, C_ILIM, 1'b0, "R3");
        idle(10, "R3");
        step(1'b1, C_DMAX, 1'b0, "R3");
        idle(3, "R3");
        step(1'b1, C_ILIM, 1'b0, "R3");
        idle(FULL, "R3");
        step(1'b0, C_PWM, 1'b1, "R7");
        // R3: drain runs into the zero floor, then a full climb is needed
        step(1'b1, C_ILIM, 1'b0, "R3");
        idle(2, "R3");
        step(1'b1, C_PWM, 1'b0, "R3");
        idle(12, "R3");
        step(1'b1, C_ILIM, 1'b0, "R3");
        idle(FULL + 2, "R3");
        step(1'b0, C_PWM, 1'b1, "R7");
        // R8: cause toggles without a strobe
        for (int i = 0; i < 12; i++) step(1'b0, C_ILIM, 1'b0, "R8");
        for (int i = 0; i < 12; i++) step(1'b0, C_SCP, 1'b0, "R8");
        idle(FULL + 2, "R8");
        // R5: consecutive short-circuit ends with idle gaps
        for (int i = 0; i < RUN; i++) begin
            step(1'b1, C_SCP, 1'b0, "R5");
            idle(3, "R5");
        end
        step(1'b1, C_PWM, 1'b0, "R5");
        idle(3, "R5");
        step(1'b0, C_PWM, 1'b1, "R7");
        // R6: runs broken by other codes
        for (int i = 0; i < RUN - 1; i++) step(1'b1, C_SCP, 1'b0, "R6");
        step(1'b1, C_PWM, 1'b0, "R6");
        for (int i = 0; i < RUN - 1; i++) step(1'b1, C_SCP, 1'b0, "R6");
        step(1'b1, C_DMAX, 1'b0, "R6");
        for (int i = 0; i < RUN - 1; i++) step(1'b1, C_SCP, 1'b0, "R6");
        step(1'b1, C_SCP, 1'b0, "R6");
        idle(2, "R6");
        // R7: both faults set, then cleared together
        step(1'b1, C_ILIM, 1'b0, "R7");
        idle(FULL + 3, "R7");
        step(1'b0, C_PWM, 1'b1, "R7");
        // R7: clear beats a same-cycle current-limit end
        step(1'b1, C_ILIM, 1'b1, "R7");
        idle(FULL + 3, "R7");
        // R7: clear beats a same-cycle short-circuit end
        for (int i = 0; i < RUN - 1; i++) step(1'b1, C_SCP, 1'b0, "R7");
        step(1'b1, C_SCP, 1'b1, "R7");
        for (int i = 0; i < RUN - 1; i++) step(1'b1, C_SCP, 1'b0, "R7");
        idle(2, "R7");
        step(1'b1, C_SCP, 1'b0, "R7");
        idle(3, "R7");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule